// File: doc/BRIEF.md
# Processor Power-Down Mode Controller

This block sits next to a processor core and decides when the core enters a low-power wait and when it leaves it. When the core retires a sleep instruction it raises a one-cycle strobe. The block then looks at two control bits. With the standby selector at 0 it enters a light or a deep power-down state, picked by the deep selector. With the standby selector at 1 it stays running and passes the request on to the standby logic that lives elsewhere.

In both power-down states the core is held halted and keeps its registers, and the clock output stays enabled. The two status pins show 2'b10 in both states and 2'b00 while running. The light state leaves the DMA controller and the bus alone. The deep state also halts the DMA controller and blocks all bus access, refresh included, so external memory must be put into self-refresh before deep entry.

Any interrupt request ends the wait. This holds even when the core's interrupt block bit is set, so the block has no mask input. The block pulses a wake strobe and latches a code that names the winning source. A reset request from the reset pin or from a watchdog overflow also ends the wait, and it wins over any interrupt that arrives in the same cycle.

Top module: `pdm_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `cpu_halt`=0, `dma_halt`=0, `bus_inhibit`=0, `stat_pins`=2'b00, `wake_stb`=0, `stby_req`=0 and `evt_code`=0, whatever the other inputs are.
- R2: In the running state, a `sleep_stb` with `stby_sel`=0, `deep_sel`=0 and no reset request gives, one cycle later, `cpu_halt`=1, `dma_halt`=0, `bus_inhibit`=0 and `stat_pins`=2'b10. These hold until a wake or reset event.
- R3: In the running state, a `sleep_stb` with `stby_sel`=0, `deep_sel`=1 and no reset request gives, one cycle later, `cpu_halt`=1, `dma_halt`=1, `bus_inhibit`=1 and `stat_pins`=2'b10.
- R4: `clk_out_en` is 1 in every state after reset.
- R5: A `sleep_stb` with `stby_sel`=1 in the running state leaves the block running (`cpu_halt`=0, `stat_pins`=2'b00). `stby_req` is 1 for exactly the next cycle.
- R6: In either power-down state, any interrupt request (`nmi_req`=1, `ext_lvl`!=0 or `per_req`=1) with no reset request gives the running outputs one cycle later. `wake_stb` is 1 for that one cycle only, and `evt_code` holds the winning source's code from then on.
- R7: The source priority is non-maskable, then external, then peripheral. The codes are NMI_CODE (default 12'h1C0) for the non-maskable source, EXT_BASE + level*EXT_STEP (default 12'h200 + level*12'h020) for the external source, and the `per_code` input for the peripheral source.
- R8: In either power-down state, `rst_pin_req` or `wdt_ovf` gives the running outputs one cycle later, with `wake_stb`=0 and `evt_code` unchanged.
- R9: When a reset request and an interrupt request arrive in the same cycle during power-down, the reset request wins: there is no wake pulse and `evt_code` does not change.
- R10: Interrupt requests in the running state have no effect: `wake_stb` stays 0 and `evt_code` is unchanged.
- R11: A `sleep_stb` during a power-down state has no effect. The state, including light versus deep, stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle pulse when a sleep instruction retires |
| stby_sel | input | 1 | Standby selector; 1 sends the sleep request to standby instead |
| deep_sel | input | 1 | Deep power-down selector |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ext_lvl | input | LVL_W | External interrupt level; 0 means no request |
| per_req | input | 1 | On-chip peripheral interrupt request |
| per_code | input | CODE_W | Event code supplied by the peripheral interrupt controller |
| rst_pin_req | input | 1 | Power-on or manual reset request from the reset pin |
| wdt_ovf | input | 1 | Power-on or manual reset request from watchdog overflow |
| cpu_halt | output | 1 | Holds the core halted with its registers kept |
| dma_halt | output | 1 | Halts the DMA controller |
| bus_inhibit | output | 1 | Blocks all bus cycles, refresh included |
| stat_pins | output | 2 | Status code: 2'b00 running, 2'b10 power-down |
| clk_out_en | output | 1 | Clock output pin enable |
| wake_stb | output | 1 | One-cycle pulse on an interrupt wake |
| evt_code | output | CODE_W | Latched code of the waking interrupt source |
| stby_req | output | 1 | One-cycle request passed on to the standby logic |

## Verification
The bench goes after the corner cases where the order of decisions matters. A watchdog overflow that arrives together with a non-maskable request must end the wait quietly. A design that checked interrupts first would pulse `wake_stb` and overwrite the event code. Simultaneous requests from all three sources check the priority: a wrong order latches the external or peripheral code in place of the non-maskable one.

A sleep strobe with the deep selector set while the block is already in light power-down must be ignored. A design that re-decodes the mode would start halting the DMA controller. Interrupts in the running state and a standby-routed sleep strobe must leave the core running. A design that got either wrong would halt the core or emit a spurious wake pulse.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_LIGHT = 2'd1,
    PM_DEEP  = 2'd2
  } pm_state_t;

  localparam logic [1:0] STAT_RUN  = 2'b00;
  localparam logic [1:0] STAT_DOWN = 2'b10;

  typedef struct packed {
    logic       cpu_halt;
    logic       dma_halt;
    logic       bus_inhibit;
    logic [1:0] stat;
  } pm_out_t;

  function automatic pm_out_t pm_decode(pm_state_t s);
    pm_out_t o;
    o.cpu_halt    = (s != PM_RUN);
    o.dma_halt    = (s == PM_DEEP);
    o.bus_inhibit = (s == PM_DEEP);
    o.stat        = (s == PM_RUN) ? STAT_RUN : STAT_DOWN;
    return o;
  endfunction

endpackage

// File: rtl/pdm_wake_arb.sv
module pdm_wake_arb #(
  parameter int                CODE_W   = 12,
  parameter int                LVL_W    = 4,
  parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0,
  parameter logic [CODE_W-1:0] EXT_BASE = 12'h200,
  parameter logic [CODE_W-1:0] EXT_STEP = 12'h020
) (
  input  logic              nmi_req,
  input  logic [LVL_W-1:0]  ext_lvl,
  input  logic              per_req,
  input  logic [CODE_W-1:0] per_code,
  output logic              any_irq,
  output logic [CODE_W-1:0] win_code
);

  logic              ext_hit;
  logic [CODE_W-1:0] ext_code;

  assign ext_hit  = |ext_lvl;
  assign ext_code = EXT_BASE + CODE_W'(ext_lvl) * EXT_STEP;
  assign any_irq  = nmi_req | ext_hit | per_req;

  // fixed order: non-maskable, external level, peripheral
  always_comb begin
    if (nmi_req)      win_code = NMI_CODE;
    else if (ext_hit) win_code = ext_code;
    else              win_code = per_code;
  end

endmodule

// File: rtl/pdm_fsm.sv
module pdm_fsm
  import pdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_stb,
  input  logic      stby_sel,
  input  logic      deep_sel,
  input  logic      any_irq,
  input  logic      rst_src,
  output pm_state_t state_nxt,
  output logic      wake_go,
  output logic      stby_go
);

  pm_state_t state_q;

  always_comb begin
    state_nxt = state_q;
    wake_go   = 1'b0;
    stby_go   = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (sleep_stb && !rst_src) begin
          if (stby_sel) stby_go   = 1'b1;
          else          state_nxt = deep_sel ? PM_DEEP : PM_LIGHT;
        end
      end
      PM_LIGHT, PM_DEEP: begin
        if (rst_src) begin
          state_nxt = PM_RUN;
        end else if (any_irq) begin
          state_nxt = PM_RUN;
          wake_go   = 1'b1;
        end
      end
      default: state_nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PM_RUN;
    else     state_q <= state_nxt;
  end

endmodule

// File: rtl/pdm_out_reg.sv
module pdm_out_reg
  import pdm_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  pm_state_t         state_nxt,
  input  logic              wake_go,
  input  logic              stby_go,
  input  logic [CODE_W-1:0] win_code,
  output pm_out_t           pm_q,
  output logic              clk_en_q,
  output logic              wake_q,
  output logic              stby_q,
  output logic [CODE_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q     <= pm_decode(PM_RUN);
      clk_en_q <= 1'b1;
      wake_q   <= 1'b0;
      stby_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      pm_q     <= pm_decode(state_nxt);
      clk_en_q <= 1'b1;
      wake_q   <= wake_go;
      stby_q   <= stby_go;
      if (wake_go) code_q <= win_code;
    end
  end

endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
#(
  parameter int                CODE_W   = 12,
  parameter int                LVL_W    = 4,
  parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0,
  parameter logic [CODE_W-1:0] EXT_BASE = 12'h200,
  parameter logic [CODE_W-1:0] EXT_STEP = 12'h020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_stb,
  input  logic              stby_sel,
  input  logic              deep_sel,
  input  logic              nmi_req,
  input  logic [LVL_W-1:0]  ext_lvl,
  input  logic              per_req,
  input  logic [CODE_W-1:0] per_code,
  input  logic              rst_pin_req,
  input  logic              wdt_ovf,
  output logic              cpu_halt,
  output logic              dma_halt,
  output logic              bus_inhibit,
  output logic [1:0]        stat_pins,
  output logic              clk_out_en,
  output logic              wake_stb,
  output logic [CODE_W-1:0] evt_code,
  output logic              stby_req
);

  logic              any_irq;
  logic [CODE_W-1:0] win_code;
  logic              rst_src;
  pm_state_t         state_nxt;
  logic              wake_go;
  logic              stby_go;
  pm_out_t           pm_q;

  assign rst_src = rst_pin_req | wdt_ovf;

  pdm_wake_arb #(
    .CODE_W(CODE_W), .LVL_W(LVL_W),
    .NMI_CODE(NMI_CODE), .EXT_BASE(EXT_BASE), .EXT_STEP(EXT_STEP)
  ) arb_i (
    .nmi_req(nmi_req), .ext_lvl(ext_lvl), .per_req(per_req),
    .per_code(per_code), .any_irq(any_irq), .win_code(win_code)
  );

  pdm_fsm fsm_i (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .deep_sel(deep_sel), .any_irq(any_irq), .rst_src(rst_src),
    .state_nxt(state_nxt), .wake_go(wake_go), .stby_go(stby_go)
  );

  pdm_out_reg #(.CODE_W(CODE_W)) out_i (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .wake_go(wake_go),
    .stby_go(stby_go), .win_code(win_code), .pm_q(pm_q),
    .clk_en_q(clk_out_en), .wake_q(wake_stb), .stby_q(stby_req),
    .code_q(evt_code)
  );

  assign cpu_halt    = pm_q.cpu_halt;
  assign dma_halt    = pm_q.dma_halt;
  assign bus_inhibit = pm_q.bus_inhibit;
  assign stat_pins   = pm_q.stat;

endmodule

// File: rtl/pdm_ctrl_chk.sv
module pdm_ctrl_chk #(
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_stb,
  input logic              stby_sel,
  input logic              deep_sel,
  input logic              nmi_req,
  input logic [LVL_W-1:0]  ext_lvl,
  input logic              per_req,
  input logic              rst_pin_req,
  input logic              wdt_ovf,
  input logic              cpu_halt,
  input logic              dma_halt,
  input logic              bus_inhibit,
  input logic [1:0]        stat_pins,
  input logic              clk_out_en,
  input logic              wake_stb,
  input logic [CODE_W-1:0] evt_code,
  input logic              stby_req
);

  logic rsrc;
  assign rsrc = rst_pin_req | wdt_ovf;

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (!cpu_halt && !dma_halt && !bus_inhibit && stat_pins == 2'b00 && !wake_stb)); // R1

  AST_LIGHT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt && sleep_stb && !stby_sel && !deep_sel && !rsrc)
      |=> (cpu_halt && !dma_halt && !bus_inhibit && stat_pins == 2'b10)); // R2

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt && sleep_stb && !stby_sel && deep_sel && !rsrc)
      |=> (cpu_halt && dma_halt && bus_inhibit && stat_pins == 2'b10)); // R3

  AST_CLKOUT_ON: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || clk_out_en); // R4

  AST_STBY_ROUTED: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt && sleep_stb && stby_sel && !rsrc) |=> (!cpu_halt && stby_req)); // R5

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_stb |=> !wake_stb); // R6

  AST_WAKE_FROM_DOWN: assert property (@(posedge clk) disable iff (rst)
    wake_stb |-> (!cpu_halt && $past(cpu_halt))); // R6

  AST_RESET_SRC_WINS: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && rsrc) |=> (!cpu_halt && !wake_stb && $stable(evt_code))); // R9

  AST_RUN_IRQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt && !sleep_stb && (nmi_req || per_req || ext_lvl != '0))
      |=> (!wake_stb && !cpu_halt && $stable(evt_code))); // R10

  AST_DOWN_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !rsrc && !nmi_req && !per_req && ext_lvl == '0)
      |=> (cpu_halt && $stable(dma_halt))); // R11

endmodule

bind pdm_ctrl pdm_ctrl_chk #(.CODE_W(CODE_W), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/pdm_ctrl_tb_top.sv
module pdm_ctrl_tb_top;

  localparam int CODE_W = 12;
  localparam int LVL_W  = 4;
  localparam logic [CODE_W-1:0] PER_CODE = 12'h5A0;
  localparam int NVEC = 19;

  // {inputs 11b: sleep,stby,deep,nmi,lvl[3:0],per,rpin,wdt}
  // {expected 7b: halt,dma,bus,stat[1:0],wake,sreq}, code 12b, tag 4b
  localparam logic [33:0] VEC [0:NVEC-1] = '{
    {11'b000_0_0000_000, 7'b0000000, 12'h000, 4'd1},  // R1 idle run
    {11'b100_0_0000_000, 7'b1001000, 12'h000, 4'd2},  // R2 light entry
    {11'b000_0_0000_000, 7'b1001000, 12'h000, 4'd2},  // R2 holds
    {11'b000_0_0000_100, 7'b0000010, 12'h5A0, 4'd6},  // R6 peripheral wake
    {11'b000_0_0000_000, 7'b0000000, 12'h5A0, 4'd6},  // R6 pulse ends
    {11'b101_0_0000_000, 7'b1111000, 12'h5A0, 4'd3},  // R3 deep entry
    {11'b000_1_0011_100, 7'b0000010, 12'h1C0, 4'd7},  // R7 nmi wins
    {11'b101_0_0000_000, 7'b1111000, 12'h1C0, 4'd3},  // R3 deep again
    {11'b000_0_0101_100, 7'b0000010, 12'h2A0, 4'd7},  // R7 ext over per
    {11'b100_0_0000_000, 7'b1001000, 12'h2A0, 4'd2},  // R2 light
    {11'b000_1_0000_001, 7'b0000000, 12'h2A0, 4'd9},  // R9 wdt + nmi
    {11'b110_0_0000_000, 7'b0000001, 12'h2A0, 4'd5},  // R5 standby routed
    {11'b000_0_0000_000, 7'b0000000, 12'h2A0, 4'd5},  // R5 one cycle
    {11'b000_1_0000_000, 7'b0000000, 12'h2A0, 4'd10}, // R10 run irq
    {11'b101_0_0000_000, 7'b1111000, 12'h2A0, 4'd3},  // R3 deep
    {11'b000_0_0000_010, 7'b0000000, 12'h2A0, 4'd8},  // R8 pin reset exit
    {11'b100_0_0000_000, 7'b1001000, 12'h2A0, 4'd2},  // R2 light
    {11'b101_0_0000_000, 7'b1001000, 12'h2A0, 4'd11}, // R11 strobe while down
    {11'b000_0_0001_000, 7'b0000010, 12'h220, 4'd6}   // R6 ext level 1
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sleep_stb = 1'b0, stby_sel = 1'b0, deep_sel = 1'b0;
  logic              nmi_req = 1'b0, per_req = 1'b0;
  logic [LVL_W-1:0]  ext_lvl = '0;
  logic              rst_pin_req = 1'b0, wdt_ovf = 1'b0;
  logic              cpu_halt, dma_halt, bus_inhibit, clk_out_en, wake_stb, stby_req;
  logic [1:0]        stat_pins;
  logic [CODE_W-1:0] evt_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pdm_ctrl #(.CODE_W(CODE_W), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .deep_sel(deep_sel), .nmi_req(nmi_req), .ext_lvl(ext_lvl),
    .per_req(per_req), .per_code(PER_CODE), .rst_pin_req(rst_pin_req),
    .wdt_ovf(wdt_ovf), .cpu_halt(cpu_halt), .dma_halt(dma_halt),
    .bus_inhibit(bus_inhibit), .stat_pins(stat_pins), .clk_out_en(clk_out_en),
    .wake_stb(wake_stb), .evt_code(evt_code), .stby_req(stby_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {sleep_stb, stby_sel, deep_sel, nmi_req, ext_lvl, per_req, rst_pin_req, wdt_ovf} = '0;
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1", "reset outputs",
          {25'd0, cpu_halt, dma_halt, bus_inhibit, stat_pins, wake_stb, stby_req}, 32'd0);
    check("R1", "reset code", {20'd0, evt_code}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      {sleep_stb, stby_sel, deep_sel, nmi_req, ext_lvl, per_req, rst_pin_req, wdt_ovf} = v[33:23];
      @(negedge clk);
      idle_inputs();
      tag = $sformatf("R%0d", v[3:0]);
      check(tag, $sformatf("vector %0d outputs", i),
            {25'd0, cpu_halt, dma_halt, bus_inhibit, stat_pins, wake_stb, stby_req},
            {25'd0, v[22:16]});
      check(tag, $sformatf("vector %0d code", i), {20'd0, evt_code}, {20'd0, v[15:4]});
      check("R4", $sformatf("vector %0d clock enable", i), {31'd0, clk_out_en}, 32'd1);
    end

    // R1: reset during deep power-down with an interrupt pending
    deep_sel = 1'b1; sleep_stb = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R3", "deep before reset", {29'd0, cpu_halt, dma_halt, bus_inhibit}, 32'd7);
    rst = 1'b1; nmi_req = 1'b1;
    @(negedge clk);
    check("R1", "reset beats irq",
          {25'd0, cpu_halt, dma_halt, bus_inhibit, stat_pins, wake_stb, stby_req}, 32'd0);
    check("R1", "reset clears code", {20'd0, evt_code}, 32'd0);
    rst = 1'b0; nmi_req = 1'b0;

    // R8: watchdog overflow alone ends light power-down
    sleep_stb = 1'b1;
    @(negedge clk);
    idle_inputs();
    wdt_ovf = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R8", "wdt exit", {30'd0, cpu_halt, wake_stb}, 32'd0);

    // R5: standby strobe with a pin reset in the same cycle does nothing
    sleep_stb = 1'b1; stby_sel = 1'b1; rst_pin_req = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R5", "standby masked by reset", {30'd0, cpu_halt, stby_req}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule